// File: doc/BRIEF.md
# Video Input Timing Analyzer

This block watches a parallel video stream in its own pixel-clock domain and works out the stream's timing. It measures the active area, the width of both sync pulses, the four porches and the level at which each sync line is active. A second clock, the reference clock, times a fixed window over which pixel clocks are counted, so the pixel rate can be reported in kHz. A stream-detected flag tells the host whether a live picture is present. The block never alters the video. All results appear as plain status outputs. Deserialization, lane decoding and any host bus sit elsewhere.

The pixel-domain measurement runs as a frame state machine with four states. `ST_IDLE` waits for the first sync. `ST_VSYNC` covers the vertical sync pulse. `ST_VBACK` covers the lines after sync that carry no valid pixel. `ST_VACT` is entered at the first valid pixel of a frame. The transitions are:

- `ST_IDLE` to `ST_VSYNC` on vertical sync assertion.
- `ST_VSYNC` to `ST_VBACK` on vertical sync deassertion.
- `ST_VBACK` to `ST_VACT` on the first data-enable rise.
- `ST_VBACK` to `ST_VSYNC` on sync assertion in a frame with no valid pixel.
- `ST_VACT` to `ST_VSYNC` on sync assertion.

The last two transitions are frame boundaries, and they copy the working values to the outputs.

Top module: `vid_timing_meter`

## Requirements
- R1: `stream_det` is 1 only while `link_lock` is high, the pixel clock is toggling and `de` has changed level within the last reference window. It falls within a few windows once any of these stops, and it is 0 in reset.
- R2: Each sync has a 2-bit polarity code: 0 for active low, 1 for active high, 2 for not available. The level held for the shorter run between edges is taken as the active one. Code 3 never appears.
- R3: A polarity code reads 2 after reset. It also reads 2 once its sync line has shown no edge for `POL_TIMEOUT` pixel clocks.
- R4: `hs_width` and `vs_width` give the length of the active sync pulse in pixel clocks.
- R5: `h_back` counts the pixel clocks from HSYNC deassertion to the first `de`-high pixel of the line. `h_front` counts the pixel clocks from the last `de`-high pixel of a line to HSYNC assertion.
- R6: Line starts are HSYNC assertions. `v_back` counts the line starts strictly after VSYNC deassertion and before the first `de`-high pixel of the frame. `v_front` counts the line starts after the last `de`-high pixel that precede VSYNC assertion. A line start that coincides with a VSYNC edge is not counted.
- R7: `act_width` is the number of `de`-high pixels in a line. `act_height` is the number of lines holding such pixels between two frame starts.
- R8: `pclk_khz` is the number of pixel clocks counted over one window of `REF_CLKS_PER_MS` reference clocks. It is within one count of the true value.
- R9: The measured values are zero after reset. They change only at a frame start, that is, at active VSYNC assertion, and they hold their last values when the stream stops.
- R10: The measurements are the same for either polarity of each sync line once the polarity is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| refclk | input | 1 | Reference clock (REF_CLKS_PER_MS cycles per ms) |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| link_lock | input | 1 | Link locked indication, asynchronous |
| de | input | 1 | Data enable, active high |
| hsync | input | 1 | Horizontal sync, either polarity |
| vsync | input | 1 | Vertical sync, either polarity |
| stream_det | output | 1 | Stream detected (refclk domain) |
| hs_pol | output | 2 | HSYNC polarity code |
| vs_pol | output | 2 | VSYNC polarity code |
| act_width | output | CW | Active pixels per line |
| act_height | output | CW | Active lines per frame |
| hs_width | output | CW | HSYNC pulse width in pixel clocks |
| vs_width | output | CW | VSYNC pulse width in pixel clocks |
| h_back | output | CW | Horizontal back porch, pixel clocks |
| h_front | output | CW | Horizontal front porch, pixel clocks |
| v_back | output | CW | Vertical back porch, lines |
| v_front | output | CW | Vertical front porch, lines |
| pclk_khz | output | FW | Pixel clock rate in kHz |

## Verification
The frame state machine could end up in the wrong state, for example missing `ST_VBACK` or leaving `ST_VACT` early. If it does, `v_back` or `act_height` is wrong, but only at the next frame start, so the bench waits several whole frames before it compares.

A polarity detector that picks the wrong active level swaps pulse and gap. `hs_width` or `vs_width` then reads as the long level, visible one frame later.

A fault in the domain crossing shows in `pclk_khz` or `stream_det` within two or three reference windows. For this reason, each stimulus change is given several windows before it is sampled.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    typedef enum logic [1:0] {
        POL_LOW  = 2'd0,
        POL_HIGH = 2'd1,
        POL_NA   = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VSYNC,
        ST_VBACK,
        ST_VACT
    } vstate_e;
endpackage

// File: rtl/vtm_pol_detect.sv
module vtm_pol_detect
    import vtm_pkg::*;
#(
    parameter int CW         = 16,
    parameter int TO_CLKS    = 4194304
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_q,
    input  logic s_p,
    output pol_e pol
);
    localparam int QW = $clog2(TO_CLKS + 1);

    logic [CW-1:0] run_c, hi_len, lo_len;
    logic [QW-1:0] quiet;
    logic          seen_hi, seen_lo;
    logic          edge_s, quiet_max;

    assign edge_s    = s_q ^ s_p;
    assign quiet_max = (quiet == QW'(TO_CLKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_c   <= '0;
            hi_len  <= '0;
            lo_len  <= '0;
            seen_hi <= 1'b0;
            seen_lo <= 1'b0;
            quiet   <= '0;
            pol     <= POL_NA;
        end else begin
            if (edge_s) begin
                run_c <= CW'(1);
                quiet <= '0;
                if (s_p) begin
                    hi_len  <= run_c;
                    seen_hi <= 1'b1;
                end else begin
                    lo_len  <= run_c;
                    seen_lo <= 1'b1;
                end
            end else begin
                if (run_c != '1) run_c <= run_c + 1'b1;
                if (!quiet_max) quiet <= quiet + 1'b1;
            end
            if (quiet_max && !edge_s) begin
                seen_hi <= 1'b0;
                seen_lo <= 1'b0;
                pol     <= POL_NA;
            end else if (seen_hi && seen_lo) begin
                pol <= (hi_len < lo_len) ? POL_HIGH : POL_LOW;
            end
        end
    end

    // R2: only the three defined codes
    p_pol_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pol != pol_e'(2'd3));
    // R3: a long quiet line reports not available
    p_quiet_na_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_max && !edge_s) |=> pol == POL_NA);
endmodule

// File: rtl/vtm_frame_meas.sv
module vtm_frame_meas
    import vtm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          de_q,
    input  logic          de_p,
    input  logic          hs_q,
    input  logic          hs_p,
    input  logic          vs_q,
    input  logic          vs_p,
    output logic [CW-1:0] o_hact,
    output logic [CW-1:0] o_vact,
    output logic [CW-1:0] o_hsw,
    output logic [CW-1:0] o_vsw,
    output logic [CW-1:0] o_hbp,
    output logic [CW-1:0] o_hfp,
    output logic [CW-1:0] o_vbp,
    output logic [CW-1:0] o_vfp
);
    vstate_e state, state_nx;

    logic hs_r, hs_f, vs_r, vs_f, de_r, de_f, commit;
    logic [CW-1:0] c_hs, c_vs, c_de;
    logic [CW-1:0] wk_hsw, wk_hbp, wk_hact, wk_hfp, wk_vsw, wk_vbp;
    logic [CW-1:0] vln, vfp_cnt, vact_cnt;
    logic          hbp_pend, line_de;

    assign hs_r   = hs_q & ~hs_p;
    assign hs_f   = ~hs_q & hs_p;
    assign vs_r   = vs_q & ~vs_p;
    assign vs_f   = ~vs_q & vs_p;
    assign de_r   = de_q & ~de_p;
    assign de_f   = ~de_q & de_p;
    assign commit = vs_r && (state == ST_VBACK || state == ST_VACT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (vs_r) state_nx = ST_VSYNC;
            ST_VSYNC: if (vs_f) state_nx = ST_VBACK;
            ST_VBACK: if (vs_r) state_nx = ST_VSYNC;
                      else if (de_r) state_nx = ST_VACT;
            ST_VACT:  if (vs_r) state_nx = ST_VSYNC;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_hs <= '0; c_vs <= '0; c_de <= '0;
            wk_hsw <= '0; wk_hbp <= '0; wk_hact <= '0;
            wk_hfp <= '0; wk_vsw <= '0; wk_vbp <= '0;
            vln <= '0; vfp_cnt <= '0; vact_cnt <= '0;
            hbp_pend <= 1'b0; line_de <= 1'b0;
            o_hact <= '0; o_vact <= '0; o_hsw <= '0; o_vsw <= '0;
            o_hbp <= '0; o_hfp <= '0; o_vbp <= '0; o_vfp <= '0;
        end else begin
            c_hs <= (hs_r | hs_f) ? CW'(1) : ((c_hs == '1) ? c_hs : c_hs + 1'b1);
            c_vs <= (vs_r | vs_f) ? CW'(1) : ((c_vs == '1) ? c_vs : c_vs + 1'b1);
            c_de <= (de_r | de_f) ? CW'(1) : ((c_de == '1) ? c_de : c_de + 1'b1);

            if (hs_f) begin
                wk_hsw   <= c_hs;
                hbp_pend <= 1'b1;
            end
            if (de_r && hbp_pend) begin
                wk_hbp   <= c_hs;
                hbp_pend <= 1'b0;
            end
            if (de_f) wk_hact <= c_de;
            if (de_r) line_de <= 1'b1;
            if (hs_r && line_de) begin
                wk_hfp  <= c_de;
                line_de <= 1'b0;
            end

            if (vs_f) begin
                wk_vsw <= c_vs;
                vln    <= '0;
            end else if (hs_r && vln != '1) begin
                vln <= vln + 1'b1;
            end
            if (state == ST_VBACK && de_r) wk_vbp <= vln;

            if (de_f)                    vfp_cnt <= '0;
            else if (hs_r && !vs_r && vfp_cnt != '1) vfp_cnt <= vfp_cnt + 1'b1;

            if (vs_r)                    vact_cnt <= '0;
            else if (de_r && vact_cnt != '1) vact_cnt <= vact_cnt + 1'b1;

            if (commit) begin
                o_hact <= wk_hact; o_vact <= vact_cnt;
                o_hsw  <= wk_hsw;  o_vsw  <= wk_vsw;
                o_hbp  <= wk_hbp;  o_hfp  <= wk_hfp;
                o_vbp  <= wk_vbp;  o_vfp  <= vfp_cnt;
            end
        end
    end

    // R9: results move only at a frame start
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(o_hact) && $stable(o_vact) && $stable(o_vbp)));
    // R7: being in the active region implies a counted active line
    p_vact_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VACT |-> vact_cnt != '0);
endmodule

// File: rtl/vtm_rate_meter.sv
module vtm_rate_meter #(
    parameter int REF_TICKS = 100000,
    parameter int FW        = 20,
    parameter int HB_BIT    = 4
) (
    input  logic          pclk,
    input  logic          refclk,
    input  logic          rst_n,
    input  logic          de_chg,
    input  logic          link_lock,
    output logic [FW-1:0] khz,
    output logic          stream_det
);
    localparam int WW = (REF_TICKS > 2) ? $clog2(REF_TICKS) : 1;

    // reference domain
    logic [WW-1:0] win_cnt;
    logic          win_tgl, win_end;
    logic [2:0]    hb_s;
    logic          hb_seen, alive;
    logic [1:0]    lk_s, dm_s;
    // pixel domain
    logic [HB_BIT:0] hb_cnt;
    logic [2:0]      wt_s;
    logic [FW-1:0]   pix_cnt;
    logic            de_seen, de_mov;

    assign win_end = (win_cnt == WW'(REF_TICKS - 1));

    always_ff @(posedge refclk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0; win_tgl <= 1'b0; hb_s <= '0;
            hb_seen <= 1'b0; alive <= 1'b0;
            lk_s <= '0; dm_s <= '0; stream_det <= 1'b0;
        end else begin
            hb_s <= {hb_s[1:0], hb_cnt[HB_BIT]};
            lk_s <= {lk_s[0], link_lock};
            dm_s <= {dm_s[0], de_mov};
            if (win_end) begin
                win_cnt <= '0;
                win_tgl <= ~win_tgl;
                alive   <= hb_seen | (hb_s[2] ^ hb_s[1]);
                hb_seen <= 1'b0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                hb_seen <= hb_seen | (hb_s[2] ^ hb_s[1]);
            end
            stream_det <= lk_s[1] & alive & dm_s[1];
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            hb_cnt <= '0; wt_s <= '0; pix_cnt <= '0;
            de_seen <= 1'b0; de_mov <= 1'b0; khz <= '0;
        end else begin
            hb_cnt <= hb_cnt + 1'b1;
            wt_s   <= {wt_s[1:0], win_tgl};
            if (wt_s[2] ^ wt_s[1]) begin
                khz     <= pix_cnt;
                pix_cnt <= FW'(1);
                de_mov  <= de_seen | de_chg;
                de_seen <= 1'b0;
            end else begin
                if (pix_cnt != '1) pix_cnt <= pix_cnt + 1'b1;
                de_seen <= de_seen | de_chg;
            end
        end
    end

    // R1: an unlocked link drops the flag on the next cycle
    p_unlock_r1: assert property (@(posedge refclk) disable iff (!rst_n)
        !lk_s[1] |=> !stream_det);
    // R8: the window counter stays inside its period
    p_win_bound_r8: assert property (@(posedge refclk) disable iff (!rst_n)
        win_cnt <= WW'(REF_TICKS - 1));
endmodule

// File: rtl/vid_timing_meter.sv
module vid_timing_meter
    import vtm_pkg::*;
#(
    parameter int CW              = 16,
    parameter int FW              = 20,
    parameter int REF_CLKS_PER_MS = 100000,
    parameter int POL_TIMEOUT     = 4194304,
    parameter int HB_BIT          = 4
) (
    input  logic          pclk,
    input  logic          refclk,
    input  logic          rst_n,
    input  logic          link_lock,
    input  logic          de,
    input  logic          hsync,
    input  logic          vsync,
    output logic          stream_det,
    output logic [1:0]    hs_pol,
    output logic [1:0]    vs_pol,
    output logic [CW-1:0] act_width,
    output logic [CW-1:0] act_height,
    output logic [CW-1:0] hs_width,
    output logic [CW-1:0] vs_width,
    output logic [CW-1:0] h_back,
    output logic [CW-1:0] h_front,
    output logic [CW-1:0] v_back,
    output logic [CW-1:0] v_front,
    output logic [FW-1:0] pclk_khz
);
    localparam int NSYNC = 2;   // index 0: horizontal, 1: vertical

    logic [NSYNC-1:0] sy_q, sy_p, sn_q, sn_p;
    logic             de_q, de_p;
    pol_e             pol [NSYNC];

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0; sy_p <= '0; de_q <= 1'b0; de_p <= 1'b0;
        end else begin
            sy_q <= {vsync, hsync};
            sy_p <= sy_q;
            de_q <= de;
            de_p <= de_q;
        end
    end

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        vtm_pol_detect #(.CW(CW), .TO_CLKS(POL_TIMEOUT)) u_pol (
            .clk(pclk), .rst_n(rst_n),
            .s_q(sy_q[i]), .s_p(sy_p[i]), .pol(pol[i])
        );
        assign sn_q[i] = sy_q[i] ^ (pol[i] == POL_LOW);
        assign sn_p[i] = sy_p[i] ^ (pol[i] == POL_LOW);
    end

    assign hs_pol = pol[0];
    assign vs_pol = pol[1];

    vtm_frame_meas #(.CW(CW)) u_meas (
        .clk(pclk), .rst_n(rst_n),
        .de_q(de_q), .de_p(de_p),
        .hs_q(sn_q[0]), .hs_p(sn_p[0]),
        .vs_q(sn_q[1]), .vs_p(sn_p[1]),
        .o_hact(act_width), .o_vact(act_height),
        .o_hsw(hs_width), .o_vsw(vs_width),
        .o_hbp(h_back), .o_hfp(h_front),
        .o_vbp(v_back), .o_vfp(v_front)
    );

    vtm_rate_meter #(.REF_TICKS(REF_CLKS_PER_MS), .FW(FW), .HB_BIT(HB_BIT)) u_rate (
        .pclk(pclk), .refclk(refclk), .rst_n(rst_n),
        .de_chg(de_q ^ de_p), .link_lock(link_lock),
        .khz(pclk_khz), .stream_det(stream_det)
    );
endmodule

// File: tb/vid_timing_meter_tb.sv
`timescale 1ns/1ps
module vid_timing_meter_tb;
    localparam int CW = 16;
    localparam int FW = 20;

    logic pclk = 1'b0, refclk = 1'b0, pclk_en = 1'b1;
    logic rst_n = 1'b0, link_lock = 1'b1;
    logic de = 1'b0, hsync = 1'b0, vsync = 1'b0;
    logic stream_det;
    logic [1:0] hs_pol, vs_pol;
    logic [CW-1:0] act_width, act_height, hs_width, vs_width;
    logic [CW-1:0] h_back, h_front, v_back, v_front;
    logic [FW-1:0] pclk_khz;

    always #2.5 if (pclk_en) pclk = ~pclk;
    always #20  refclk = ~refclk;

    vid_timing_meter #(.CW(CW), .FW(FW), .REF_CLKS_PER_MS(25),
                       .POL_TIMEOUT(1000), .HB_BIT(4)) u_dut (
        .pclk(pclk), .refclk(refclk), .rst_n(rst_n), .link_lock(link_lock),
        .de(de), .hsync(hsync), .vsync(vsync), .stream_det(stream_det),
        .hs_pol(hs_pol), .vs_pol(vs_pol),
        .act_width(act_width), .act_height(act_height),
        .hs_width(hs_width), .vs_width(vs_width),
        .h_back(h_back), .h_front(h_front), .v_back(v_back), .v_front(v_front),
        .pclk_khz(pclk_khz)
    );

    // {hsw, hbp, hact, hfp, vsw_lines, vbp, vact, vfp, hs_active_high, vs_active_high}
    localparam int NV = 3;
    localparam int VEC [NV][10] = '{
        '{4, 3, 10, 5, 2, 3, 6, 2, 1, 1},
        '{6, 2, 16, 3, 3, 2, 5, 4, 0, 0},
        '{3, 5,  8, 7, 1, 4, 9, 3, 1, 0}
    };

    int cfg [10];
    logic gen_on = 1'b0, de_kill = 1'b0, done = 1'b0;
    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic play_frame();
        int lh, lv;
        lh = cfg[0] + cfg[1] + cfg[2] + cfg[3];
        lv = cfg[4] + cfg[5] + cfg[6] + cfg[7];
        for (int ln = 0; ln < lv; ln++) begin
            for (int px = 0; px < lh; px++) begin
                logic hs_a, vs_a, de_a;
                hs_a = (px < cfg[0]);
                vs_a = (ln < cfg[4]);
                de_a = (ln >= cfg[4] + cfg[5]) && (ln < cfg[4] + cfg[5] + cfg[6]) &&
                       (px >= cfg[0] + cfg[1]) && (px < cfg[0] + cfg[1] + cfg[2]);
                hsync = (cfg[8] != 0) ? hs_a : ~hs_a;
                vsync = (cfg[9] != 0) ? vs_a : ~vs_a;
                de    = de_a & ~de_kill;
                @(negedge pclk);
            end
        end
    endtask

    initial begin
        forever begin
            if (gen_on) play_frame();
            else @(negedge pclk);
        end
    end

    task automatic wait_pclk(input int n);
        repeat (n) @(negedge pclk);
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 10; k++) cfg[k] = VEC[0][k];
        #80;
        // R9 R3 R1: reset values
        chk("R9 act_width reset", int'(act_width), 0);
        chk("R9 v_front reset", int'(v_front), 0);
        chk("R3 hs_pol reset", int'(hs_pol), 2);
        chk("R3 vs_pol reset", int'(vs_pol), 2);
        chk("R1 stream_det reset", int'(stream_det), 0);
        #20 rst_n = 1'b1;
        gen_on = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int lh;
            for (int k = 0; k < 10; k++) cfg[k] = VEC[v][k];
            lh = cfg[0] + cfg[1] + cfg[2] + cfg[3];
            wait_pclk(6000);
            chk("R7 act_width",  int'(act_width),  cfg[2]);
            chk("R7 act_height", int'(act_height), cfg[6]);
            chk("R4 hs_width",   int'(hs_width),   cfg[0]);
            chk("R4 vs_width",   int'(vs_width),   cfg[4] * lh);
            chk("R5 h_back",     int'(h_back),     cfg[1]);
            chk("R5 h_front",    int'(h_front),    cfg[3]);
            chk("R6 v_back",     int'(v_back),     cfg[5]);
            chk("R6 v_front",    int'(v_front),    cfg[7]);
            chk("R2 R10 hs_pol", int'(hs_pol),     cfg[8]);
            chk("R2 R10 vs_pol", int'(vs_pol),     cfg[9]);
        end

        // R8: 25 refclk of 40 ns = 1000 ns = 200 pixel clocks
        chk("R8 pclk_khz in range", int'(pclk_khz >= 199 && pclk_khz <= 201), 1);
        chk("R1 stream_det live", int'(stream_det), 1);

        link_lock = 1'b0; #500;
        chk("R1 stream_det unlocked", int'(stream_det), 0);
        link_lock = 1'b1; #4000;
        chk("R1 stream_det relock", int'(stream_det), 1);

        pclk_en = 1'b0; #3000;
        chk("R1 stream_det pclk stopped", int'(stream_det), 0);
        pclk_en = 1'b1; #5000;
        chk("R1 stream_det pclk back", int'(stream_det), 1);

        de_kill = 1'b1; #6000;
        chk("R1 stream_det de frozen", int'(stream_det), 0);
        de_kill = 1'b0; wait_pclk(6000);
        chk("R1 stream_det de back", int'(stream_det), 1);
        chk("R7 act_width after restore", int'(act_width), cfg[2]);

        gen_on = 1'b0;
        wait_pclk(1500 + 600);
        chk("R3 hs_pol quiet", int'(hs_pol), 2);
        chk("R3 vs_pol quiet", int'(vs_pol), 2);
        chk("R9 act_width held", int'(act_width), cfg[2]);
        chk("R9 v_back held", int'(v_back), cfg[5]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule